// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Front End

This block turns three asynchronous input pins into interrupt requests for a CPU core. Software picks an edge sense for each pin: off, falling, rising or both edges. A separate enable bit decides whether the pin may raise an interrupt at all or is left as plain I/O. Each pin is first brought into the clock domain by a two-flop synchronizer. An edge is a change between two successive synchronized samples that matches the selected sense.

The core supplies a machine-cycle strobe. Edges found between strobes are held in a pending vector and moved into sticky flags at the next strobed clock edge. The request output is evaluated only on strobed edges, so the interrupt sequencer sees a new flag one machine cycle after it was latched. Flags are cleared by software, which writes 0 to a flag bit, or by a per-channel acknowledge pulse from the sequencer. An edge that lands in the same clock as a clear wins, and the flag stays set.

Top module: `edge_irq_front`

## Requirements
- R1: While reset is asserted, and after it is released, the flags, the request output and every readable register are 0.
- R2: Register map by reg_addr_i: 0 is the mode register, 1 is the enable register, 2 is the flag register, and 3 reads 0. In the mode register, channel 0 uses bits [1:0], channel 1 uses bits [3:2] and channel 2 uses bits [5:4]; bits [7:6] read 0. The enable register uses bits [2:0], one per channel, and its upper bits read 0. A write takes effect at the clock edge where reg_we_i is high. reg_rdata_o shows the addressed register without delay.
- R3: Mode codes: 2'b00 detects nothing, 2'b01 falling edges, 2'b10 rising edges, 2'b11 both edges. Writing 8'b0001_0001 to the mode register selects falling edges on channels 0 and 2.
- R4: A channel whose enable bit is 0 never sets its flag, whatever its pin does.
- R5: A pin change applied before clock edge k is detected at edge k+2 at the earliest. The flag sets at the first clock edge at or after k+2 where mcyc_i is high. A detected edge is held until then, however long mcyc_i stays low.
- R6: irq_req_o changes only at clock edges where mcyc_i is high. At such an edge it takes the OR of (flags AND enable) as it stood just before that edge. Clearing an enable bit masks the request but leaves the flag set.
- R7: Writing to the flag register clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R8: A high bit of ack_i for one clock clears only that channel's flag.
- R9: When a clear (write or acknowledge) and a detected edge for the same channel take effect at the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins_i | input | 3 | Asynchronous interrupt pins, one per channel |
| mcyc_i | input | 1 | Machine-cycle strobe: flags latch and the request updates at edges where it is high |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| ack_i | input | 3 | Per-channel acknowledge pulse that clears the flag |
| irq_flags_o | output | 3 | Sticky interrupt flags |
| irq_req_o | output | 1 | Interrupt request to the sequencer |

## Verification
The assertions assume that register writes and acknowledges are idle while reset is asserted. They also assume that mcyc_i and the register bus change only between clock edges, so that each strobe or write belongs to exactly one edge. The bench drives every input on the falling clock edge and keeps the bus idle until several clocks after reset is released. A pin changes only after the synchronizer has settled from its previous change, and a flag is read no earlier than the cycle in which R5 and R6 say it changes.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int unsigned REG_MODE = 0;
  localparam int unsigned REG_PEN  = 1;
  localparam int unsigned REG_FLAG = 2;

endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int unsigned NCH    = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic [NCH-1:0] async_i,
  output logic [NCH-1:0] sync_o
);

  logic [NCH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NCH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect
  import edge_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n,
  input  logic       smp_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  output logic       hit_o
);

  logic       prev_q;
  edge_mode_e mode;
  logic       rise_ok, fall_ok;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= smp_i;
  end

  always_comb begin
    mode    = edge_mode_e'(mode_i);
    rise_ok = (mode == EDGE_RISE) || (mode == EDGE_BOTH);
    fall_ok = (mode == EDGE_FALL) || (mode == EDGE_BOTH);
    hit_o   = en_i & ((rise_ok & smp_i & ~prev_q) | (fall_ok & ~smp_i & prev_q));
  end

endmodule

// File: rtl/edge_irq_flags.sv
module edge_irq_flags #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           mcyc_i,
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] flags_o,
  output logic           req_o
);

  logic [NCH-1:0] seen_q, seen_d;
  logic [NCH-1:0] flag_q, flag_d;
  logic           req_q, req_d;

  // Edges found between strobes wait in seen_q; a strobe moves them into
  // the flags. The set term is ORed in after the clear so a simultaneous
  // edge wins.
  always_comb begin
    seen_d = mcyc_i ? '0 : (seen_q | hit_i);
    flag_d = (flag_q & ~clr_i) | (mcyc_i ? (seen_q | hit_i) : '0);
    req_d  = |(flag_q & en_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      flag_q <= '0;
      req_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      flag_q <= flag_d;
      if (mcyc_i) req_q <= req_d;
    end
  end

  assign flags_o = flag_q;
  assign req_o   = req_q;

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 2,
  localparam int unsigned MW = 2 * NCH
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NCH-1:0] ack_i,
  input  logic [NCH-1:0] flags_i,
  output logic [DW-1:0]  rdata_o,
  output logic [MW-1:0]  mode_o,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] clr_o
);

  logic [MW-1:0]  mode_q, mode_d;
  logic [NCH-1:0] en_q, en_d;
  logic           sel_mode, sel_pen, sel_flag;

  always_comb begin
    sel_mode = (addr_i == AW'(REG_MODE));
    sel_pen  = (addr_i == AW'(REG_PEN));
    sel_flag = (addr_i == AW'(REG_FLAG));
    mode_d   = (we_i && sel_mode) ? wdata_i[MW-1:0]  : mode_q;
    en_d     = (we_i && sel_pen)  ? wdata_i[NCH-1:0] : en_q;
    clr_o    = ack_i | ((we_i && sel_flag) ? ~wdata_i[NCH-1:0] : '0);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    if (sel_mode)      rdata_o = DW'(mode_q);
    else if (sel_pen)  rdata_o = DW'(en_q);
    else if (sel_flag) rdata_o = DW'(flags_i);
    else               rdata_o = '0;
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;

endmodule

// File: rtl/edge_irq_front.sv
module edge_irq_front #(
  parameter int unsigned NCH         = 3,
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pins_i,
  input  logic           mcyc_i,
  input  logic           reg_we_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  input  logic [NCH-1:0] ack_i,
  output logic [NCH-1:0] irq_flags_o,
  output logic           irq_req_o
);

  localparam int unsigned MW = 2 * NCH;

  logic [1:0]     rst_pipe_q;
  logic           rst_n;
  logic [NCH-1:0] pin_sync;
  logic [MW-1:0]  mode_vec;
  logic [NCH-1:0] en_vec;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  edge_irq_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .async_i (pins_i),
    .sync_o  (pin_sync)
  );

  edge_irq_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ack_i   (ack_i),
    .flags_i (irq_flags_o),
    .rdata_o (reg_rdata_o),
    .mode_o  (mode_vec),
    .en_o    (en_vec),
    .clr_o   (clr_vec)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    edge_irq_detect u_det (
      .clk_i  (clk_i),
      .rst_n  (rst_n),
      .smp_i  (pin_sync[c]),
      .mode_i (mode_vec[2*c +: 2]),
      .en_i   (en_vec[c]),
      .hit_o  (hit_vec[c])
    );
  end

  edge_irq_flags #(.NCH(NCH)) u_flags (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .mcyc_i  (mcyc_i),
    .hit_i   (hit_vec),
    .clr_i   (clr_vec),
    .en_i    (en_vec),
    .flags_o (irq_flags_o),
    .req_o   (irq_req_o)
  );

endmodule

// File: rtl/edge_irq_front_chk.sv
module edge_irq_front_chk
  import edge_irq_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 2
) (
  input logic           clk_i,
  input logic           rst_n,
  input logic           mcyc_i,
  input logic           reg_we_i,
  input logic [AW-1:0]  reg_addr_i,
  input logic [DW-1:0]  reg_wdata_i,
  input logic [NCH-1:0] ack_i,
  input logic [NCH-1:0] flags_i,
  input logic [NCH-1:0] en_i,
  input logic           req_i
);

  logic [NCH-1:0] clr_ext;
  logic           pen_wr;

  assign clr_ext = ack_i |
    ((reg_we_i && reg_addr_i == AW'(REG_FLAG)) ? ~reg_wdata_i[NCH-1:0] : '0);
  assign pen_wr  = reg_we_i && (reg_addr_i == AW'(REG_PEN));

  AST_PEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(pen_wr) |-> (en_i == $past(reg_wdata_i[NCH-1:0])));  // R2

  AST_FLAG_SET_ON_MCYC: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((flags_i & ~$past(flags_i)) != '0) |-> $past(mcyc_i));  // R5

  AST_REQ_MOVES_ON_MCYC: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_i != $past(req_i)) |-> $past(mcyc_i));  // R6

  AST_REQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_i && !$past(req_i)) |-> ($past(flags_i & en_i) != '0));  // R6

  AST_FLAG_DROP_NEEDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (($past(flags_i) & ~flags_i & ~$past(clr_ext)) == '0));  // R7

endmodule

bind edge_irq_front edge_irq_front_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .mcyc_i      (mcyc_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .ack_i       (ack_i),
  .flags_i     (irq_flags_o),
  .en_i        (en_vec),
  .req_i       (irq_req_o)
);

// File: tb/edge_irq_front_tb.sv
`timescale 1ns/1ps
module edge_irq_front_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] pins = '0;
  logic       mcyc = 1'b1;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] ack = '0;
  logic [2:0] flags;
  logic       req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_irq_front u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .mcyc_i(mcyc),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .irq_flags_o(flags), .irq_req_o(req)
  );

  // {ch[1:0], mode[1:0], en, start level, expected flag}
  localparam logic [6:0] VEC [12] = '{
    {2'd0, 2'b01, 1'b1, 1'b1, 1'b1},
    {2'd0, 2'b01, 1'b1, 1'b0, 1'b0},
    {2'd0, 2'b10, 1'b1, 1'b0, 1'b1},
    {2'd0, 2'b10, 1'b1, 1'b1, 1'b0},
    {2'd0, 2'b11, 1'b1, 1'b0, 1'b1},
    {2'd0, 2'b11, 1'b1, 1'b1, 1'b1},
    {2'd0, 2'b00, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'b10, 1'b0, 1'b0, 1'b0},
    {2'd1, 2'b11, 1'b1, 1'b1, 1'b1},
    {2'd2, 2'b01, 1'b1, 1'b1, 1'b1},
    {2'd2, 2'b10, 1'b1, 1'b0, 1'b1},
    {2'd2, 2'b00, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clk1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    clk1();
    we = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    @(negedge clk);
    repeat (3) clk1();
    // R1: during reset
    chk("R1 flags in reset", 8'(flags), 8'h00);
    chk("R1 req in reset", 8'(req), 8'h00);
    rst_ni = 1'b1;
    repeat (4) clk1();
    rd(2'd0, d); chk("R1 mode after reset", d, 8'h00);
    rd(2'd1, d); chk("R1 enable after reset", d, 8'h00);
    rd(2'd2, d); chk("R1 flags reg after reset", d, 8'h00);
    chk("R1 req after reset", 8'(req), 8'h00);

    // R2: register widths and unused address
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 mode width", d, 8'h3F);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 enable width", d, 8'h07);
    rd(2'd3, d); chk("R2 unused address", d, 8'h00);
    // R3: example mode value
    wr(2'd0, 8'b0001_0001); rd(2'd0, d); chk("R3 mode readback", d, 8'h11);
    pins = 3'b111; repeat (4) clk1(); wr(2'd2, 8'h00); clk1();
    pins = 3'b000; repeat (4) clk1();
    chk("R3 falling on ch0 and ch2 only", 8'(flags), 8'h05);

    // table: mode, enable and level patterns (R3, R4)
    mcyc = 1'b1;
    for (int i = 0; i < 12; i++) begin
      logic [6:0] v;
      int ch;
      v = VEC[i];
      ch = int'(v[6:5]);
      pins = v[1] ? 3'b111 : 3'b000;
      wr(2'd0, 8'(v[4:3]) << (2 * ch));
      wr(2'd1, 8'(v[2]) << ch);
      repeat (4) clk1();
      wr(2'd2, 8'h00);
      clk1();
      pins[ch] = ~v[1];
      repeat (4) clk1();
      chk($sformatf("R3/R4 vector %0d flags", i), 8'(flags), 8'(v[0]) << ch);
      chk($sformatf("R6 vector %0d req", i), 8'(req), 8'(v[0]));
    end

    // R5: exact latency with strobe always high
    pins = 3'b000;
    wr(2'd0, 8'h3F); wr(2'd1, 8'h07);
    repeat (4) clk1(); wr(2'd2, 8'h00); clk1(); clk1();
    pins[0] = 1'b1;
    clk1(); clk1();
    chk("R5 no flag after k+1", 8'(flags), 8'h00);
    clk1();
    chk("R5 flag at k+2", 8'(flags), 8'h01);
    chk("R6 req still low at k+2", 8'(req), 8'h00);
    clk1();
    chk("R6 req at k+3", 8'(req), 8'h01);

    // R5: detected edge held while strobe is low
    mcyc = 1'b0;
    pins[1] = 1'b1;
    repeat (6) clk1();
    chk("R5 held while strobe low", 8'(flags), 8'h01);
    mcyc = 1'b1; clk1();
    chk("R5 latched on strobe", 8'(flags), 8'h03);

    // R6: request follows flags only on strobe
    mcyc = 1'b0;
    wr(2'd2, 8'h00);
    chk("R7 clear all", 8'(flags), 8'h00);
    chk("R6 req held without strobe", 8'(req), 8'h01);
    clk1();
    chk("R6 req still held", 8'(req), 8'h01);
    mcyc = 1'b1; clk1();
    chk("R6 req drops on strobe", 8'(req), 8'h00);

    // R6: enable masks request, flag stays
    pins[2] = 1'b1; repeat (4) clk1();
    chk("R6 flag ch2 set", 8'(flags), 8'h04);
    wr(2'd1, 8'h03); clk1(); clk1();
    chk("R6 flag kept when disabled", 8'(flags), 8'h04);
    chk("R6 req masked", 8'(req), 8'h00);
    wr(2'd1, 8'h07); clk1();

    // R7: partial clear, ones leave flags alone
    pins = 3'b000; repeat (4) clk1();
    chk("R7 all set", 8'(flags), 8'h07);
    wr(2'd2, 8'hFE);
    chk("R7 clear only ch0", 8'(flags), 8'h06);

    // R8: acknowledge one channel
    ack = 3'b010; clk1(); ack = 3'b000;
    chk("R8 ack clears ch1 only", 8'(flags), 8'h04);

    // R9: clear collides with edge on ch0
    pins[0] = 1'b1;
    clk1(); clk1();
    wr(2'd2, 8'h00);
    chk("R9 edge beats clear", 8'(flags), 8'h01);
    ack = 3'b001; clk1(); ack = 3'b000;
    chk("R8 ack without edge clears", 8'(flags), 8'h00);

    // R1: reset clears everything again
    rst_ni = 1'b0; clk1();
    chk("R1 flags on reset", 8'(flags), 8'h00);
    rd(2'd1, d); chk("R1 enable on reset", d, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule